// File: doc/BRIEF.md
# Keyed-Unlock Watchdog Timer

This block is a watchdog timer with four 32-bit registers reached through a single-cycle read/write port: a control/status word, the live counter, the timeout limit and the refresh window. Its configuration is guarded. Software first writes a two-word key to the counter address and waits until the unlocked status bit reads 1. It then writes the whole control word in one access and waits until the reconfiguration-done bit returns to 1. Until software repeats that handshake, no configuration register can change.

Once enabled, the counter advances on ticks from the selected source. Two tick-enable inputs stand in for the slow low-power clock and for an auxiliary source. When the count reaches the timeout limit, the block raises a sticky interrupt flag and pulses a reset request for one cycle. A separate two-word refresh key, written to the counter address, reloads the counter to zero. A nonzero window value rejects a refresh that arrives too early.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the control/status word reads 0x0000_0020 (update permission set, everything else clear), the counter reads 0, the timeout limit reads 0x0000_0400, the window reads 0, and rst_req and irq are 0.
- R2: The registers decode at byte offsets 0x0 control/status, 0x4 counter, 0x8 timeout limit and 0xC window. A read returns the addressed register in the same cycle, and an unmapped address reads 0.
- R3: Writing 0x0000_C520 and then 0x0000_D928 as the very next write to offset 0x4 sets control bit 11 (unlocked) on that second write's clock edge. Any other value written in between sends the key detector back to idle, and bit 11 then stays 0.
- R4: While bit 11 is 0, writes to the timeout limit, the window, and every control field other than bit 14 are ignored.
- R5: A control write while unlocked clears bit 10 on its own clock edge. Two edges later the new control fields take effect, bit 10 becomes 1 and bit 11 becomes 0. Bit 10 stays 1 until the next accepted unlock.
- R6: When no control write arrives, bit 11 stays 1 for exactly 256 clock cycles after the unlock edge and then returns to 0.
- R7: Bit 7 enables counting. Bits [9:8] choose the tick: 0 = every clock, 1 = tick_lp, 2 = tick_aux, 3 = no tick.
- R8: On a tick with the counter at or above the timeout limit, the counter returns to 0, bit 14 (irq) is set, and rst_req is 1 for the single following cycle.
- R9: Writing 1 to bit 14 clears the flag whether the block is locked or not. A write of 0 there leaves it as it is.
- R10: Writing 0x0000_B32D and then 0x0000_4CD2 as the next write to offset 0x4 reloads the counter to 0 on that edge. A broken pair has no effect on the count.
- R11: With a nonzero window, a refresh pair is ignored while the counter is below the window value. A window of 0 accepts a refresh at any count.
- R12: While the update-permission bit 5 is 0, the unlock key is ignored, so the configuration stays frozen until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| tick_lp | input | 1 | Low-power tick enable (source 1) |
| tick_aux | input | 1 | Auxiliary tick enable (source 2) |
| irq | output | 1 | Timeout flag (control bit 14) |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
Reads are combinational, so the bench samples a register in the half cycle after the edge that was due to change it. A write driven before edge E is visible at the next falling edge. This places the unlock, refresh, flag-clear and timeout effects one sample after their stimulus, and the rst_req pulse is checked at that sample and found gone one sample later. The two-edge reconfiguration delay is checked by reading the control word at three consecutive falling edges after the control write, and the bit 10 values must be 0, 0 and then 1. The 256-cycle unlock lifetime is probed at the last sample where bit 11 must still be 1 and at the next one.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned CS_UPD    = 5;
  localparam int unsigned CS_EN     = 7;
  localparam int unsigned CS_SRC_LO = 8;
  localparam int unsigned CS_RCS    = 10;
  localparam int unsigned CS_ULK    = 11;
  localparam int unsigned CS_FLAG   = 14;

  localparam logic [31:0] KEY_UNLOCK_A  = 32'h0000_C520;
  localparam logic [31:0] KEY_UNLOCK_B  = 32'h0000_D928;
  localparam logic [31:0] KEY_REFRESH_A = 32'h0000_B32D;
  localparam logic [31:0] KEY_REFRESH_B = 32'h0000_4CD2;

  localparam logic [3:0] OFF_CS  = 4'h0;
  localparam logic [3:0] OFF_CNT = 4'h4;
  localparam logic [3:0] OFF_TOV = 4'h8;
  localparam logic [3:0] OFF_WIN = 4'hC;

  typedef struct packed {
    logic [1:0] src;
    logic       en;
    logic       upd;
  } wdt_cfg_t;

  localparam wdt_cfg_t CFG_RESET = '{src: 2'd0, en: 1'b0, upd: 1'b1};

  function automatic logic [31:0] cs_pack(wdt_cfg_t c, logic flag, logic ulk, logic rcs);
    logic [31:0] w;
    w = '0;
    w[CS_FLAG]         = flag;
    w[CS_ULK]          = ulk;
    w[CS_RCS]          = rcs;
    w[CS_SRC_LO +: 2]  = c.src;
    w[CS_EN]           = c.en;
    w[CS_UPD]          = c.upd;
    return w;
  endfunction

  function automatic wdt_cfg_t cs_unpack(logic [31:0] w);
    wdt_cfg_t c;
    c.src = w[CS_SRC_LO +: 2];
    c.en  = w[CS_EN];
    c.upd = w[CS_UPD];
    return c;
  endfunction

  function automatic logic tick_pick(logic [1:0] src, logic t_lp, logic t_aux);
    case (src)
      2'd0:    return 1'b1;
      2'd1:    return t_lp;
      2'd2:    return t_aux;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic refresh_ok(logic [31:0] cnt, logic [31:0] win);
    return (win == '0) || (cnt >= win);
  endfunction

  function automatic logic expired(logic [31:0] cnt, logic [31:0] lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cnt,
  input  logic [DW-1:0] wdata,
  output logic          unlock_hit,
  output logic          refresh_hit
);

  typedef enum logic [1:0] {KS_IDLE, KS_ULK_B, KS_REF_B} ks_state_t;

  ks_state_t state_q, state_d;

  always_comb begin
    state_d     = state_q;
    unlock_hit  = 1'b0;
    refresh_hit = 1'b0;
    if (wr_cnt) begin
      if (state_q == KS_ULK_B && wdata == DW'(KEY_UNLOCK_B)) begin
        unlock_hit = 1'b1;
        state_d    = KS_IDLE;
      end else if (state_q == KS_REF_B && wdata == DW'(KEY_REFRESH_B)) begin
        refresh_hit = 1'b1;
        state_d     = KS_IDLE;
      end else if (wdata == DW'(KEY_UNLOCK_A)) begin
        state_d = KS_ULK_B;
      end else if (wdata == DW'(KEY_REFRESH_A)) begin
        state_d = KS_REF_B;
      end else begin
        state_d = KS_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/wdt_cfg.sv
module wdt_cfg
  import wdt_pkg::*;
#(
  parameter int unsigned DW            = 32,
  parameter int unsigned UNLOCK_CYCLES = 256,
  parameter logic [31:0] TOVAL_RST     = 32'h0000_0400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          unlock_hit,
  input  logic          wr_cs,
  input  logic          wr_tov,
  input  logic          wr_win,
  input  logic [DW-1:0] wdata,
  output wdt_cfg_t      cfg,
  output logic [DW-1:0] toval,
  output logic [DW-1:0] win,
  output logic          ulk,
  output logic          rcs,
  output logic          cfg_wr_accept,
  output logic          apply_evt,
  output logic          unlock_evt
);

  localparam int unsigned WCW = (UNLOCK_CYCLES > 1) ? $clog2(UNLOCK_CYCLES) : 1;
  localparam logic [WCW-1:0] WIN_LAST = WCW'(UNLOCK_CYCLES - 1);

  logic [1:0]     apply_sr;
  logic           pending;
  wdt_cfg_t       pend_cfg;
  logic [WCW-1:0] ulk_cnt;
  logic           open_wr;

  assign pending       = |apply_sr;
  assign apply_evt     = apply_sr[1];
  assign unlock_evt    = unlock_hit && cfg.upd && !pending;
  assign open_wr       = ulk && !pending;
  assign cfg_wr_accept = wr_cs && open_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      apply_sr <= '0;
      pend_cfg <= CFG_RESET;
      cfg      <= CFG_RESET;
      ulk      <= 1'b0;
      rcs      <= 1'b0;
      ulk_cnt  <= '0;
      toval    <= DW'(TOVAL_RST);
      win      <= '0;
    end else begin
      apply_sr <= {apply_sr[0], cfg_wr_accept};
      if (cfg_wr_accept) begin
        pend_cfg <= cs_unpack(32'(wdata));
        rcs      <= 1'b0;
      end
      if (apply_evt) begin
        cfg <= pend_cfg;
        rcs <= 1'b1;
        ulk <= 1'b0;
      end else if (unlock_evt) begin
        ulk     <= 1'b1;
        rcs     <= 1'b0;
        ulk_cnt <= '0;
      end else if (open_wr) begin
        if (ulk_cnt == WIN_LAST) ulk <= 1'b0;
        else                     ulk_cnt <= ulk_cnt + 1'b1;
      end
      if (open_wr && wr_tov) toval <= wdata;
      if (open_wr && wr_win) win   <= wdata;
    end
  end

endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wdt_cfg_t      cfg,
  input  logic [DW-1:0] toval,
  input  logic [DW-1:0] win,
  input  logic          tick_lp,
  input  logic          tick_aux,
  input  logic          refresh_hit,
  input  logic          flag_clr,
  output logic [DW-1:0] cnt,
  output logic          flag,
  output logic          rst_req,
  output logic          timeout_evt,
  output logic          refresh_evt
);

  logic tick;

  assign tick        = cfg.en && tick_pick(cfg.src, tick_lp, tick_aux);
  assign refresh_evt = refresh_hit && refresh_ok(32'(cnt), 32'(win));
  assign timeout_evt = tick && !refresh_evt && expired(32'(cnt), 32'(toval));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      flag    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (refresh_evt || timeout_evt) cnt <= '0;
      else if (tick)                  cnt <= cnt + 1'b1;
      if (timeout_evt)   flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      rst_req <= timeout_evt;
    end
  end

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int unsigned AW            = 4,
  parameter int unsigned DW            = 32,
  parameter int unsigned UNLOCK_CYCLES = 256,
  parameter logic [31:0] TOVAL_RST     = 32'h0000_0400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tick_lp,
  input  logic          tick_aux,
  output logic          irq,
  output logic          rst_req
);

  logic          wr_any, wr_cs, wr_cnt, wr_tov, wr_win, flag_clr;
  logic          unlock_hit, refresh_hit;
  wdt_cfg_t      cfg_q;
  logic [DW-1:0] toval_q, win_q, cnt_q;
  logic          ulk_q, rcs_q, flag_q;
  logic          cfg_wr_accept, apply_evt, unlock_evt;
  logic          timeout_evt, refresh_evt;

  assign wr_any   = bus_sel && bus_we;
  assign wr_cs    = wr_any && (bus_addr == AW'(OFF_CS));
  assign wr_cnt   = wr_any && (bus_addr == AW'(OFF_CNT));
  assign wr_tov   = wr_any && (bus_addr == AW'(OFF_TOV));
  assign wr_win   = wr_any && (bus_addr == AW'(OFF_WIN));
  assign flag_clr = wr_cs && bus_wdata[CS_FLAG];

  wdt_keyseq #(.DW(DW)) u_keyseq (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_cnt      (wr_cnt),
    .wdata       (bus_wdata),
    .unlock_hit  (unlock_hit),
    .refresh_hit (refresh_hit)
  );

  wdt_cfg #(
    .DW            (DW),
    .UNLOCK_CYCLES (UNLOCK_CYCLES),
    .TOVAL_RST     (TOVAL_RST)
  ) u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .unlock_hit    (unlock_hit),
    .wr_cs         (wr_cs),
    .wr_tov        (wr_tov),
    .wr_win        (wr_win),
    .wdata         (bus_wdata),
    .cfg           (cfg_q),
    .toval         (toval_q),
    .win           (win_q),
    .ulk           (ulk_q),
    .rcs           (rcs_q),
    .cfg_wr_accept (cfg_wr_accept),
    .apply_evt     (apply_evt),
    .unlock_evt    (unlock_evt)
  );

  wdt_count #(.DW(DW)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg         (cfg_q),
    .toval       (toval_q),
    .win         (win_q),
    .tick_lp     (tick_lp),
    .tick_aux    (tick_aux),
    .refresh_hit (refresh_hit),
    .flag_clr    (flag_clr),
    .cnt         (cnt_q),
    .flag        (flag_q),
    .rst_req     (rst_req),
    .timeout_evt (timeout_evt),
    .refresh_evt (refresh_evt)
  );

  assign irq = flag_q;

  always_comb begin
    case (bus_addr)
      AW'(OFF_CS):  bus_rdata = DW'(cs_pack(cfg_q, flag_q, ulk_q, rcs_q));
      AW'(OFF_CNT): bus_rdata = cnt_q;
      AW'(OFF_TOV): bus_rdata = toval_q;
      AW'(OFF_WIN): bus_rdata = win_q;
      default:      bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
  import wdt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_req,
  input logic          flag,
  input logic          ulk,
  input logic          rcs,
  input wdt_cfg_t      cfg,
  input logic [DW-1:0] cnt,
  input logic          cfg_wr_accept,
  input logic          apply_evt,
  input logic          unlock_evt,
  input logic          timeout_evt,
  input logic          refresh_evt
);

  assert_unlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_evt |=> ulk);

  assert_locked_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ulk && !apply_evt) |=> $stable(cfg));

  assert_rcs_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_accept |=> (!rcs && !apply_evt));

  assert_rcs_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_accept |=> ##1 apply_evt);

  assert_rcs_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    apply_evt |=> (rcs && !ulk));

  assert_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (rst_req && flag && cnt == '0));

  assert_req_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(timeout_evt));

  assert_refresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_evt |=> (cnt == '0));

  assert_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.upd && !ulk) |=> !ulk);

endmodule

bind wdt_keyed wdt_keyed_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rst_req       (rst_req),
  .flag          (flag_q),
  .ulk           (ulk_q),
  .rcs           (rcs_q),
  .cfg           (cfg_q),
  .cnt           (cnt_q),
  .cfg_wr_accept (cfg_wr_accept),
  .apply_evt     (apply_evt),
  .unlock_evt    (unlock_evt),
  .timeout_evt   (timeout_evt),
  .refresh_evt   (refresh_evt)
);

// File: tb/wdt_keyed_bench.sv
`timescale 1ns/1ps
module wdt_keyed_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_lp = 1'b0, tick_aux = 1'b0;
  logic        irq, rst_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  wdt_keyed u_wdt_keyed (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_lp(tick_lp), .tick_aux(tick_aux), .irq(irq), .rst_req(rst_req)
  );

  localparam logic [3:0] A_CS = 4'h0, A_CNT = 4'h4, A_TOV = 4'h8, A_WIN = 4'hC;
  localparam logic [31:0] UA = 32'hC520, UB = 32'hD928, FA = 32'hB32D, FB = 32'h4CD2;
  localparam logic [31:0] ALL = 32'hFFFF_FFFF;

  // vector: {op(1=read check), tag, addr, data/expected, mask}
  localparam int NV = 23;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 4'd1, A_CS,  32'h20,  ALL},     // R1
    {1'b1, 4'd1, A_CNT, 32'h0,   ALL},     // R1
    {1'b1, 4'd2, A_TOV, 32'h400, ALL},     // R1 R2
    {1'b1, 4'd1, A_WIN, 32'h0,   ALL},     // R1
    {1'b0, 4'd4, A_CS,  32'hA0,  ALL},     // R4 locked control write
    {1'b1, 4'd4, A_CS,  32'h20,  ALL},     // R4
    {1'b0, 4'd4, A_TOV, 32'h5,   ALL},     // R4
    {1'b1, 4'd4, A_TOV, 32'h400, ALL},     // R4
    {1'b0, 4'd3, A_CNT, UA,      ALL},     // R3 broken key
    {1'b0, 4'd3, A_CNT, 32'h1234, ALL},
    {1'b0, 4'd3, A_CNT, UB,      ALL},
    {1'b1, 4'd3, A_CS,  32'h0,   32'h800}, // R3
    {1'b0, 4'd3, A_CNT, UA,      ALL},     // R3 good key
    {1'b0, 4'd3, A_CNT, UB,      ALL},
    {1'b1, 4'd3, A_CS,  32'h800, 32'hC00}, // R3
    {1'b0, 4'd2, A_TOV, 32'h5,   ALL},
    {1'b0, 4'd2, A_WIN, 32'h0,   ALL},
    {1'b1, 4'd2, A_TOV, 32'h5,   ALL},     // R2
    {1'b0, 4'd5, A_CS,  32'h1A0, ALL},     // R5 control write
    {1'b1, 4'd5, A_CS,  32'h820, ALL},     // R5 after its edge
    {1'b1, 4'd5, A_CS,  32'h820, ALL},     // R5 one edge later
    {1'b1, 4'd5, A_CS,  32'h5A0, ALL},     // R5 applied
    {1'b1, 4'd7, A_CNT, 32'h0,   ALL}      // R7 source 1 idle
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_lp = 1'b1;
      @(negedge clk);
      tick_lp = 1'b0;
    end
  endtask

  task automatic unlock();
    wr(A_CNT, UA);
    wr(A_CNT, UB);
  endtask

  task automatic refresh();
    wr(A_CNT, FA);
    wr(A_CNT, FB);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] c1, c2;
    step(3);
    check("R1 rst_req", {31'b0, rst_req}, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    step(1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) begin
        logic [31:0] v;
        rd(VEC[i][67:64], v);
        check($sformatf("R%0d vec%0d", VEC[i][71:68], i), v & VEC[i][31:0], VEC[i][63:32]);
        @(negedge clk);
      end else begin
        wr(VEC[i][67:64], VEC[i][63:32]);
      end
    end

    // R8 timeout on tick_lp, limit 5
    ticks(5);
    rd_chk("R8 count before limit", A_CNT, 32'd5);
    check("R8 no request yet", {31'b0, rst_req}, 32'h0);
    ticks(1);
    check("R8 request pulse", {31'b0, rst_req}, 32'h1);
    check("R8 irq set", {31'b0, irq}, 32'h1);
    rd_chk("R8 count reloaded", A_CNT, 32'd0);
    step(1);
    check("R8 pulse one cycle", {31'b0, rst_req}, 32'h0);

    // R9 flag clear while locked, other fields untouched
    wr(A_CS, 32'h4000);
    check("R9 irq cleared", {31'b0, irq}, 32'h0);
    rd_chk("R9 R4 control unchanged", A_CS, 32'h5A0);

    // R10 refresh
    ticks(3);
    rd_chk("R10 count", A_CNT, 32'd3);
    refresh();
    rd_chk("R10 refresh reload", A_CNT, 32'd0);
    ticks(2);
    wr(A_CNT, FA); wr(A_CNT, 32'h0); wr(A_CNT, FB);
    rd_chk("R10 broken refresh", A_CNT, 32'd2);

    // R11 window
    unlock();
    wr(A_WIN, 32'd4);
    wr(A_CS, 32'h1A0);
    step(2);
    rd_chk("R5 reapplied", A_CS, 32'h5A0);
    rd_chk("R11 window value", A_WIN, 32'd4);
    refresh();
    rd_chk("R11 early refresh ignored", A_CNT, 32'd2);
    ticks(2);
    refresh();
    rd_chk("R11 refresh in window", A_CNT, 32'd0);

    // R6 unlock lifetime
    unlock();
    step(255);
    rd_chk("R6 still unlocked", A_CS, 32'h5A0 & ~32'h400 | 32'h800);
    step(1);
    rd_chk("R6 relocked", A_CS, 32'h1A0);
    wr(A_TOV, 32'd7);
    rd_chk("R4 limit after relock", A_TOV, 32'd5);

    // R7 bus clock source
    unlock();
    wr(A_TOV, 32'd1000);
    wr(A_WIN, 32'd0);
    wr(A_CS, 32'h0A0);
    step(3);
    rd(A_CNT, c1);
    step(10);
    rd(A_CNT, c2);
    check("R7 every clock", c2 - c1, 32'd10);

    // R12 update permission removed
    unlock();
    wr(A_CS, 32'h380);
    step(2);
    rd_chk("R12 frozen config", A_CS, 32'h780);
    unlock();
    rd_chk("R12 unlock refused", A_CS, 32'h780);
    wr(A_CS, 32'h1A0);
    step(3);
    rd_chk("R12 control unchanged", A_CS, 32'h780);

    rd_chk("R2 unmapped", 4'h2, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule